// File: doc/BRIEF.md
# Dual-Rail Completion Detector

This block watches a bus of dual-rail bits and reports, on one output, whether the bus currently holds a complete data word or a complete spacer. Each bit has a true rail and a false rail. A bit carries data when exactly one rail has left the spacer level. It carries spacer when both rails sit at the spacer level. The block acts as the acknowledge source of a four-phase handshake. The output `done` rises once every bit carries data. It falls once every bit has returned to spacer. Between those two points it holds its value, so a bus that is partly filled or partly drained never makes it toggle.

A parameter sets the spacer polarity. With `SPACER_LOW`, the spacer is both rails low and each bit's validity is the OR of its rails. With `SPACER_HIGH`, the spacer is both rails high and each bit's validity comes from the AND of its rails, where a low AND means data. The per-bit validity flags feed a balanced tree of 2-input hysteretic C-elements. Each C-element is a small two-state machine with states `CE_EMPTY` and `CE_FULL`. The `FILL` transition moves it from `CE_EMPTY` to `CE_FULL` when both inputs are high. The `DRAIN` transition moves it from `CE_FULL` to `CE_EMPTY` when both inputs are low. It stays in its state whenever its inputs disagree. Each tree node is one clocked stage, so the root follows a complete bus after a fixed number of edges. When the width is not a power of two, spare leaves copy the top bit.

Top module: `dr_completion_detect`

## Requirements
- R1: While `rst_n` is low, `done` is low whatever the rails carry. After release, `done` follows R4 to R6 starting from the empty state.
- R2: With `SPACER_LOW`, bit b carries data when `rail_t[b] | rail_f[b]` is 1, and carries spacer when both rails are 0.
- R3: With `SPACER_HIGH`, bit b carries data when `rail_t[b] & rail_f[b]` is 0 (one rail low), and carries spacer when both rails are 1.
- R4: `done` rises only after every bit carries data. While any bit still holds spacer during a fill, `done` stays low.
- R5: `done` falls only after every bit holds spacer. While any bit still carries data during a drain, `done` stays high.
- R6: `done` changes exactly DEPTH rising edges after the first edge at which the bus is completely valid or completely spacer. DEPTH = 1 for WIDTH = 1, otherwise ceil(log2 WIDTH).
- R7: For a WIDTH that is not a power of two, behaviour and latency are the same as in R4 to R6.
- R8: Each fill phase and each drain phase produces exactly one transition of `done`, for any order of bit arrival and any grouping of arrivals into cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that advances every C-element stage |
| rst_n | input | 1 | Asynchronous active-low reset; forces every node empty |
| rail_t | input | WIDTH | True rail of each dual-rail bit |
| rail_f | input | WIDTH | False rail of each dual-rail bit |
| done | output | 1 | Completion flag: high once the bus is full, low once it is empty |

## Verification
Two things can happen in the same cycle: the final bit of a phase can arrive, and other bits can arrive too, including both inputs of one C-element at once. The alternative is the final bit arriving alone after the rest of the tree has already settled into a partial state. The bench provokes both cases. It shuffles the arrival order and releases random batches of one to three bits per cycle, and it also runs bursts in which the whole bus switches in one cycle. In each case the bench judges the result the same way. `done` must still hold its old value one edge before the DEPTH-th edge. It must hold its new value right after that edge. It must make exactly one transition per phase.

// File: rtl/dr_cd_pkg.sv
package dr_cd_pkg;

    // Spacer polarity of the dual-rail encoding
    typedef enum logic {
        SPACER_LOW  = 1'b0,   // spacer = both rails 0
        SPACER_HIGH = 1'b1    // spacer = both rails 1
    } spacer_e;

    // State of one hysteretic 2-input C-element
    typedef enum logic {
        CE_EMPTY = 1'b0,
        CE_FULL  = 1'b1
    } ce_state_e;

    // Number of C-element stages between the leaves and the root
    function automatic int tree_depth(input int width);
        return (width <= 1) ? 1 : $clog2(width);
    endfunction

endpackage

// File: rtl/dr_rail_validity.sv
module dr_rail_validity #(
    parameter int                  WIDTH  = 8,
    parameter dr_cd_pkg::spacer_e  SPACER = dr_cd_pkg::SPACER_LOW
) (
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic [WIDTH-1:0] bit_valid
);

    // One flag per bit, normalised so that 1 always means "carries data".
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        if (SPACER == dr_cd_pkg::SPACER_LOW) begin : g_rtz
            assign bit_valid[b] = rail_t[b] | rail_f[b];
        end else begin : g_rto
            assign bit_valid[b] = ~(rail_t[b] & rail_f[b]);
        end
    end

endmodule

// File: rtl/dr_c_element.sv
module dr_c_element (
    input  logic clk,
    input  logic rst_n,
    input  logic in_a,
    input  logic in_b,
    output logic out_q
);

    import dr_cd_pkg::*;

    ce_state_e state_q;
    ce_state_e state_d;

    // Transition logic: FILL when both inputs high, DRAIN when both low
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CE_EMPTY: if (in_a && in_b)   state_d = CE_FULL;   // FILL
            CE_FULL:  if (!in_a && !in_b) state_d = CE_EMPTY;  // DRAIN
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CE_EMPTY;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        out_q = (state_q == CE_FULL);
    end

endmodule

// File: rtl/dr_c_tree.sv
module dr_c_tree #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] leaf,
    output logic             root
);

    localparam int DEPTH  = dr_cd_pkg::tree_depth(WIDTH);
    localparam int LEAVES = 1 << DEPTH;

    // Heap layout: node i has children 2i and 2i+1; leaves at LEAVES..2*LEAVES-1
    logic [2*LEAVES-1:1] heap;

    for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
        localparam int SRC = (j < WIDTH) ? j : WIDTH - 1;
        assign heap[LEAVES + j] = leaf[SRC];
    end

    for (genvar i = 1; i < LEAVES; i++) begin : g_node
        dr_c_element u_ce (
            .clk   (clk),
            .rst_n (rst_n),
            .in_a  (heap[2*i]),
            .in_b  (heap[2*i + 1]),
            .out_q (heap[i])
        );
    end

    assign root = heap[1];

endmodule

// File: rtl/dr_completion_detect.sv
module dr_completion_detect #(
    parameter int                  WIDTH  = 8,
    parameter dr_cd_pkg::spacer_e  SPACER = dr_cd_pkg::SPACER_LOW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic             done
);

    logic [WIDTH-1:0] bit_valid;

    dr_rail_validity #(
        .WIDTH  (WIDTH),
        .SPACER (SPACER)
    ) u_valid (
        .rail_t    (rail_t),
        .rail_f    (rail_f),
        .bit_valid (bit_valid)
    );

    dr_c_tree #(
        .WIDTH (WIDTH)
    ) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .leaf  (bit_valid),
        .root  (done)
    );

endmodule

// File: rtl/dr_cd_checker.sv
module dr_cd_checker #(
    parameter int                  WIDTH  = 8,
    parameter dr_cd_pkg::spacer_e  SPACER = dr_cd_pkg::SPACER_LOW
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] rail_t,
    input logic [WIDTH-1:0] rail_f,
    input logic             done
);

    localparam int DEPTH = dr_cd_pkg::tree_depth(WIDTH);
    localparam int CW    = $clog2(DEPTH + 2);
    localparam logic [CW-1:0] SAT = CW'(DEPTH + 1);

    logic all_data;
    logic all_space;

    always_comb begin
        if (SPACER == dr_cd_pkg::SPACER_LOW) begin
            all_data  = &(rail_t | rail_f);
            all_space = ~|(rail_t | rail_f);
        end else begin
            all_data  = &(~(rail_t & rail_f));
            all_space = &(rail_t & rail_f);
        end
    end

    // Consecutive edges with the bus completely full / completely empty
    logic [CW-1:0] data_run;
    logic [CW-1:0] space_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_run  <= '0;
            space_run <= '0;
        end else begin
            data_run  <= !all_data  ? '0 : (data_run  == SAT ? SAT : data_run  + 1'b1);
            space_run <= !all_space ? '0 : (space_run == SAT ? SAT : space_run + 1'b1);
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> !done);

    assert_rise_after_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> data_run >= CW'(DEPTH));

    assert_fall_after_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> space_run >= CW'(DEPTH));

    assert_full_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_run == SAT) |-> done);

    assert_empty_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (space_run == SAT) |-> !done);

endmodule

bind dr_completion_detect dr_cd_checker #(
    .WIDTH  (WIDTH),
    .SPACER (SPACER)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rail_t (rail_t),
    .rail_f (rail_f),
    .done   (done)
);

// File: tb/test_dr_completion_detect.sv
module test_dr_completion_detect;

    import dr_cd_pkg::*;

    localparam int NZ = 8;   // SPACER_LOW instance
    localparam int NO = 5;   // SPACER_HIGH instance, not a power of two

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    // Logical bus state driven by the bench: valid flag and data value per bit
    logic [NZ-1:0] val_z = '0, dat_z = '0;
    logic [NO-1:0] val_o = '0, dat_o = '0;

    logic [NZ-1:0] t_z, f_z;
    logic [NO-1:0] t_o, f_o;
    logic          done_z, done_o;

    // Rail encodings per R2 / R3
    assign t_z = val_z & dat_z;
    assign f_z = val_z & ~dat_z;
    assign t_o = ~(val_o & dat_o);
    assign f_o = ~(val_o & ~dat_o);

    dr_completion_detect #(.WIDTH(NZ), .SPACER(SPACER_LOW)) i_dr_completion_detect (
        .clk(clk), .rst_n(rst_n), .rail_t(t_z), .rail_f(f_z), .done(done_z));

    dr_completion_detect #(.WIDTH(NO), .SPACER(SPACER_HIGH)) i_dr_completion_detect_rto (
        .clk(clk), .rst_n(rst_n), .rail_t(t_o), .rail_f(f_o), .done(done_o));

    int vectors = 0;
    int errors  = 0;
    int edges_z = 0;
    int edges_o = 0;

    always @(posedge done_z or negedge done_z) edges_z++;
    always @(posedge done_o or negedge done_o) edges_o++;

    function automatic int depth_of(input int n);
        int d = 0;
        while ((1 << d) < n) d++;
        return (d == 0) ? 1 : d;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_bit(input bit rto, input int b, input bit to_data);
        if (rto) begin
            val_o[b] = to_data;
            if (to_data) dat_o[b] = 1'($urandom);
        end else begin
            val_z[b] = to_data;
            if (to_data) dat_z[b] = 1'($urandom);
        end
    endtask

    // One handshake phase on one instance; burst = whole bus in one cycle
    task automatic run_phase(input bit rto, input bit to_data, input bit burst);
        int n     = rto ? NO : NZ;
        int depth = depth_of(n);
        int order[8];
        int k = 0;
        int old_v = to_data ? 0 : 1;
        int new_v = to_data ? 1 : 0;
        string tag_hold = to_data ? (rto ? "R4/R3/R7" : "R4/R2") : (rto ? "R5/R3/R7" : "R5/R2");
        for (int i = 0; i < n; i++) order[i] = i;
        for (int i = n - 1; i > 0; i--) begin
            int j   = int'($urandom % (i + 1));
            int tmp = order[i];
            order[i] = order[j];
            order[j] = tmp;
        end
        @(negedge clk);
        if (rto) edges_o = 0; else edges_z = 0;
        while (k < n) begin
            int batch = burst ? n : 1 + int'($urandom % 3);
            if (k + batch > n) batch = n - k;
            for (int i = 0; i < batch; i++) set_bit(rto, order[k + i], to_data);
            k += batch;
            if (k < n) begin
                repeat (depth + 1) @(posedge clk);
                @(negedge clk);
                check(tag_hold, rto ? done_o : done_z, old_v);
            end
        end
        // Last bit applied just after a falling edge: R6 latency window
        repeat (depth - 1) @(posedge clk);
        @(negedge clk);
        check("R6 before", rto ? done_o : done_z, old_v);
        @(posedge clk);
        @(negedge clk);
        check(rto ? "R6/R7 after" : "R6 after", rto ? done_o : done_z, new_v);
        repeat (2) @(negedge clk);
        check("R8 transitions", rto ? edges_o : edges_z, 1);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        #2 rst_n = 1'b0;
        // R1: full bus during reset must not raise done
        val_z = '1; val_o = '1;
        repeat (4) @(negedge clk);
        check("R1 in reset z", done_z, 0);
        check("R1 in reset o", done_o, 0);
        val_z = '0; val_o = '0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 after release z", done_z, 0);
        check("R1 after release o", done_o, 0);

        // Directed bursts: whole bus switches in one cycle
        run_phase(1'b0, 1'b1, 1'b1);
        run_phase(1'b0, 1'b0, 1'b1);
        run_phase(1'b1, 1'b1, 1'b1);
        run_phase(1'b1, 1'b0, 1'b1);

        // Random arrival orders and batch sizes
        for (int r = 0; r < 40; r++) begin
            bit rto = 1'($urandom);
            run_phase(rto, 1'b1, 1'b0);
            run_phase(rto, 1'b0, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule